// File: doc/BRIEF.md
# Ping-Pong Receive Buffer for a Bulk OUT Endpoint

This block buffers the data of one USB bulk OUT endpoint in two banks of equal size. At any moment one bank is attached to the serial interface engine, which writes the bytes of each received packet into it. The other bank is attached to the CPU side, which drains it one byte per read strobe. Reads come either as programmed reads (`cpu_rd`) or as DMA acknowledges (`dma_ack`) answering a request (`dma_req`) that also obeys a terminal-count input.

When the engine-side bank holds a good packet and the CPU-side bank is empty, the banks swap. The CPU-side byte count is loaded with the packet length and a one-cycle data-ready pulse is raised. Firmware reads the count and then exactly that many bytes. The block drives a single NAK flag for the handshake logic. Hardware raises the flag while a finished packet waits for the CPU side to drain. Firmware can also force the flag and hold it. A synchronous clear empties both banks.

The engine side is a two-state machine. In `SIE_OPEN` the bank accepts bytes. In `SIE_HELD` a finished packet waits for a swap. `SIE_OPEN -> SIE_HELD` happens on a good packet end while CPU data is still unread. `SIE_HELD -> SIE_OPEN` happens on the swap. A good end with the CPU side already empty swaps directly and stays in `SIE_OPEN`. Clear returns the machine to `SIE_OPEN`.

The DMA machine has three states. `DMA_IDLE -> DMA_REQ` happens when DMA is enabled and unread bytes exist. `DMA_REQ -> DMA_IDLE` happens on the last-byte read or when DMA is disabled. `DMA_REQ -> DMA_TC` happens on terminal count. `DMA_TC -> DMA_IDLE` happens on the next swap or when DMA is disabled. Clear returns the machine to `DMA_IDLE`.

Top module: `bulk_rx_pingpong`

## Requirements
- R1: After reset, `nak`, `dma_req` and `rdy_irq` are 0 and `cpu_cnt` is 0.
- R2: Banks swap only when a good packet is complete and `cpu_cnt` is 0. If `sie_end` with `sie_good`=1 is sampled at edge k while `cpu_cnt` is 0, then after edge k `rdy_irq` is 1 for exactly one cycle, `cpu_cnt` equals the number of bytes written, and the bytes are presented in arrival order.
- R3: A good packet ending while `cpu_cnt` is nonzero is held, and `nak` is 1 from the next cycle. Once `cpu_cnt` reaches 0, the swap happens at the following edge: `rdy_irq` pulses, `cpu_cnt` loads the held length, and `nak` returns to 0.
- R4: A firmware write (`fw_nak_we`) with `fw_nak_val`=1 makes `nak` 1 from the next cycle. `nak` stays 1, across swaps, until a firmware write of 0. While `nak` is 1, the engine inputs are ignored.
- R5: `clr` sampled at an edge makes `nak`, `cpu_cnt` and `dma_req` 0 after it. `clr` discards any held packet and drops the firmware hold.
- R6: A packet ended with `sie_good`=0, or cut by `sie_abort`, is discarded without a swap. The next packet is written from bank offset 0.
- R7: Each read strobe (`cpu_rd` or `dma_ack`) with `cpu_cnt` nonzero consumes the byte shown on `cpu_data` and decrements `cpu_cnt`. A read strobe with `cpu_cnt` 0 has no effect.
- R8: `dma_req` is 1 only while `cpu_cnt` is nonzero. Setting `dma_en` while unread bytes remain, including bytes left after programmed reads, raises `dma_req` one cycle later.
- R9: A read of the last byte while `dma_req` is 1 makes `dma_req` 0 from the next cycle.
- R10: `dma_tc` sampled with `dma_req` 1 makes `dma_req` 0 from the next cycle. The request stays 0 until a swap, and it is raised again one cycle after the swap.
- R11: At most DEPTH (64) bytes of a packet are stored, and later bytes are dropped. `sie_vld` is ignored in a cycle that also carries `sie_end` or `sie_abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of both banks and the NAK flag |
| sie_vld | input | 1 | Received byte valid |
| sie_data | input | DW | Received byte |
| sie_end | input | 1 | Packet end strobe |
| sie_good | input | 1 | Packet status with `sie_end`: 1 good, 0 bad |
| sie_abort | input | 1 | Packet abort strobe |
| fw_nak_we | input | 1 | Firmware write strobe for the NAK flag |
| fw_nak_val | input | 1 | Value written to the NAK flag |
| nak | output | 1 | Endpoint answers NAK when 1 |
| cpu_rd | input | 1 | Programmed read strobe |
| cpu_data | output | DW | Byte at the CPU-side read position |
| cpu_cnt | output | $clog2(DEPTH+1) | Unread bytes in the CPU-side bank |
| rdy_irq | output | 1 | One-cycle data-ready pulse after a swap |
| dma_en | input | 1 | DMA mode enable |
| dma_ack | input | 1 | DMA read strobe |
| dma_tc | input | 1 | DMA terminal count |
| dma_req | output | 1 | DMA request |

## Verification
The hardest situation to reach is the swap that follows a drain. It needs a packet already held behind a non-empty CPU bank, so the stimulus sends two packets back to back before reading anything. The hold created this way also carries the firmware-forced NAK across a swap and the terminal-count lockout past the last programmed read. In both cases the bench checks the exact cycle of the deferred swap and of the re-armed request.

// File: rtl/pp_pkg.sv
package pp_pkg;
    typedef enum logic {SIE_OPEN, SIE_HELD} sie_st_t;
    typedef enum logic [1:0] {DMA_IDLE, DMA_REQ, DMA_TC} dma_st_t;
endpackage

// File: rtl/pp_bank_mem.sv
module pp_bank_mem #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] bank_rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [DW-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b)))
                mem[wr_addr] <= wr_data;
        end
        assign bank_rd[b] = mem[rd_addr];
    end

    assign rd_data = bank_rd[rd_bank];
endmodule

// File: rtl/pp_sie_fsm.sv
module pp_sie_fsm
    import pp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          sie_vld,
    input  logic          sie_end,
    input  logic          sie_good,
    input  logic          sie_abort,
    input  logic          fw_we,
    input  logic          fw_val,
    input  logic          cpu_empty,
    output logic          nak,
    output logic          swap,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          wr_bank,
    output logic [CW-1:0] pkt_len
);
    sie_st_t       st, st_nx;
    logic [CW-1:0] wr_ptr;
    logic          fw_hold, fw_hold_nx, nak_nx, bank_q;
    logic          open_in, ended_ok, dropped;

    // next state
    always_comb begin
        open_in  = (st == SIE_OPEN) && !nak && !clr;
        ended_ok = open_in && sie_end && sie_good && !sie_abort;
        dropped  = open_in && (sie_abort || (sie_end && !sie_good));
        st_nx    = st;
        unique case (st)
            SIE_OPEN: if (ended_ok && !cpu_empty) st_nx = SIE_HELD;
            SIE_HELD: if (cpu_empty) st_nx = SIE_OPEN;
            default:  st_nx = SIE_OPEN;
        endcase
        if (clr) st_nx = SIE_OPEN;
        fw_hold_nx = clr ? 1'b0 : (fw_we ? fw_val : fw_hold);
        nak_nx     = !clr && (fw_hold_nx || (st_nx == SIE_HELD));
    end

    // outputs
    always_comb begin
        swap    = !clr && cpu_empty && ((st == SIE_HELD) || ended_ok);
        wr_en   = open_in && sie_vld && !sie_end && !sie_abort
                  && (wr_ptr < CW'(DEPTH));
        wr_addr = wr_ptr[AW-1:0];
        wr_bank = bank_q;
        pkt_len = wr_ptr;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= SIE_OPEN;
            fw_hold <= 1'b0;
            nak     <= 1'b0;
            bank_q  <= 1'b0;
            wr_ptr  <= '0;
        end else begin
            st      <= st_nx;
            fw_hold <= fw_hold_nx;
            nak     <= nak_nx;
            if (clr)       bank_q <= 1'b0;
            else if (swap) bank_q <= ~bank_q;
            if (clr || swap || dropped) wr_ptr <= '0;
            else if (wr_en)             wr_ptr <= wr_ptr + CW'(1);
        end
    end

    AST_CLR_DROPS_NAK: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !nak);                                          // R5
    AST_FW_FORCES_NAK: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_we && fw_val && !clr) |=> nak);                     // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr <= CW'(DEPTH));                                  // R11
endmodule

// File: rtl/pp_cpu_side.sv
module pp_cpu_side #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] load_len,
    input  logic          rd_stb,
    output logic [CW-1:0] cnt,
    output logic [AW-1:0] rd_addr,
    output logic          empty,
    output logic          last
);
    logic [AW-1:0] rd_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            rd_ptr <= '0;
        end else if (clr) begin
            cnt    <= '0;
            rd_ptr <= '0;
        end else if (load) begin
            cnt    <= load_len;
            rd_ptr <= '0;
        end else if (rd_stb && (cnt != '0)) begin
            cnt    <= cnt - CW'(1);
            rd_ptr <= rd_ptr + AW'(1);
        end
    end

    assign rd_addr = rd_ptr;
    assign empty   = (cnt == '0);
    assign last    = (cnt == CW'(1));

    AST_SWAP_ONLY_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (cnt == '0));                                  // R2
    AST_EMPTY_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (cnt == '0) && !load && !clr) |=> (cnt == '0)); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));                                     // R11
endmodule

// File: rtl/pp_dma_fsm.sv
module pp_dma_fsm
    import pp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic dma_en,
    input  logic dma_tc,
    input  logic rd_stb,
    input  logic cnt_zero,
    input  logic last,
    input  logic swap,
    output logic dma_req
);
    dma_st_t st, st_nx;

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            DMA_IDLE: if (dma_en && !cnt_zero && !(rd_stb && last)) st_nx = DMA_REQ;
            DMA_REQ: begin
                if (!dma_en)              st_nx = DMA_IDLE;
                else if (dma_tc)          st_nx = DMA_TC;
                else if (rd_stb && last)  st_nx = DMA_IDLE;
            end
            DMA_TC:   if (!dma_en || swap) st_nx = DMA_IDLE;
            default:  st_nx = DMA_IDLE;
        endcase
        if (clr) st_nx = DMA_IDLE;
    end

    // outputs
    always_comb dma_req = (st == DMA_REQ);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= DMA_IDLE;
        else        st <= st_nx;
    end

    AST_REQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> !cnt_zero);                                 // R8
    AST_LAST_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && rd_stb && last) |=> !dma_req);              // R9
    AST_TC_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_tc) |=> !dma_req);                      // R10
endmodule

// File: rtl/bulk_rx_pingpong.sv
module bulk_rx_pingpong #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         sie_vld,
    input  logic [DW-1:0]                sie_data,
    input  logic                         sie_end,
    input  logic                         sie_good,
    input  logic                         sie_abort,
    input  logic                         fw_nak_we,
    input  logic                         fw_nak_val,
    output logic                         nak,
    input  logic                         cpu_rd,
    output logic [DW-1:0]                cpu_data,
    output logic [$clog2(DEPTH+1)-1:0]   cpu_cnt,
    output logic                         rdy_irq,
    input  logic                         dma_en,
    input  logic                         dma_ack,
    input  logic                         dma_tc,
    output logic                         dma_req
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          swap, wr_en, wr_bank, cpu_empty, cpu_last, rd_stb;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [CW-1:0] pkt_len;

    assign rd_stb = cpu_rd || dma_ack;

    pp_sie_fsm #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_sie (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .sie_vld(sie_vld), .sie_end(sie_end), .sie_good(sie_good),
        .sie_abort(sie_abort), .fw_we(fw_nak_we), .fw_val(fw_nak_val),
        .cpu_empty(cpu_empty), .nak(nak), .swap(swap), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_bank(wr_bank), .pkt_len(pkt_len)
    );

    pp_bank_mem #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
        .wr_data(sie_data), .rd_bank(~wr_bank), .rd_addr(rd_addr),
        .rd_data(cpu_data)
    );

    pp_cpu_side #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_cpu (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load(swap), .load_len(pkt_len),
        .rd_stb(rd_stb), .cnt(cpu_cnt), .rd_addr(rd_addr),
        .empty(cpu_empty), .last(cpu_last)
    );

    pp_dma_fsm u_dma (
        .clk(clk), .rst_n(rst_n), .clr(clr), .dma_en(dma_en), .dma_tc(dma_tc),
        .rd_stb(rd_stb), .cnt_zero(cpu_empty), .last(cpu_last), .swap(swap),
        .dma_req(dma_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdy_irq <= 1'b0;
        else        rdy_irq <= swap;
    end

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_irq |=> !rdy_irq);                                  // R2
endmodule

// File: tb/bulk_rx_pingpong_bench.sv
module bulk_rx_pingpong_bench;
    localparam int DEPTH = 64;
    localparam int DW    = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 0, rst_n = 0, clr = 0;
    logic sie_vld = 0, sie_end = 0, sie_good = 0, sie_abort = 0;
    logic [DW-1:0] sie_data = '0;
    logic fw_nak_we = 0, fw_nak_val = 0, cpu_rd = 0;
    logic dma_en = 0, dma_ack = 0, dma_tc = 0;
    logic nak, rdy_irq, dma_req;
    logic [DW-1:0] cpu_data;
    logic [CW-1:0] cpu_cnt;

    int vectors = 0, miscompares = 0;
    bit done = 0;
    byte unsigned exp_q[$];

    always #2.5 clk = ~clk;

    bulk_rx_pingpong #(.DEPTH(DEPTH), .DW(DW)) u_bulk_rx_pingpong (
        .clk(clk), .rst_n(rst_n), .clr(clr), .sie_vld(sie_vld),
        .sie_data(sie_data), .sie_end(sie_end), .sie_good(sie_good),
        .sie_abort(sie_abort), .fw_nak_we(fw_nak_we), .fw_nak_val(fw_nak_val),
        .nak(nak), .cpu_rd(cpu_rd), .cpu_data(cpu_data), .cpu_cnt(cpu_cnt),
        .rdy_irq(rdy_irq), .dma_en(dma_en), .dma_ack(dma_ack),
        .dma_tc(dma_tc), .dma_req(dma_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: sends a packet, pushes the expected bytes when it should land
    task automatic send_pkt(input int n, input int base, input bit good, input bit acc);
        for (int i = 0; i < n; i++) begin
            sie_vld  = 1;
            sie_data = DW'(base + i);
            if (good && acc && i < DEPTH) exp_q.push_back(byte'(base + i));
            @(negedge clk);
        end
        sie_vld  = 0;
        sie_end  = 1;
        sie_good = good;
        @(negedge clk);
        sie_end  = 0;
        sie_good = 0;
    endtask

    task automatic send_abort(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            sie_vld  = 1;
            sie_data = DW'(base + i);
            @(negedge clk);
        end
        sie_vld   = 1;
        sie_abort = 1;
        @(negedge clk);
        sie_vld   = 0;
        sie_abort = 0;
    endtask

    // monitor: pops expected bytes and compares them as they are read
    task automatic pull(input int n, input bit use_dma, input string tag);
        for (int i = 0; i < n; i++) begin
            byte unsigned e = exp_q.pop_front();
            chk(tag, int'(cpu_data), int'(e));
            if (use_dma) dma_ack = 1; else cpu_rd = 1;
            @(negedge clk);
        end
        cpu_rd  = 0;
        dma_ack = 0;
    endtask

    task automatic fw_write(input bit v);
        fw_nak_we  = 1;
        fw_nak_val = v;
        @(negedge clk);
        fw_nak_we  = 0;
        fw_nak_val = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 nak", nak, 0);
        chk("R1 cnt", cpu_cnt, 0);
        chk("R1 dma_req", dma_req, 0);
        chk("R1 irq", rdy_irq, 0);

        // R2 direct swap
        send_pkt(5, 8'h10, 1, 1);
        chk("R2 irq", rdy_irq, 1);
        chk("R2 cnt", cpu_cnt, 5);
        chk("R2 nak", nak, 0);
        @(negedge clk);
        chk("R2 irq pulse", rdy_irq, 0);

        // R3 held packet behind unread data
        send_pkt(3, 8'h40, 1, 1);
        chk("R3 nak held", nak, 1);
        chk("R3 no swap", rdy_irq, 0);
        chk("R3 cnt kept", cpu_cnt, 5);
        pull(5, 0, "R7 pio data");
        chk("R3 cnt drained", cpu_cnt, 0);
        chk("R3 nak before swap", nak, 1);
        @(negedge clk);
        chk("R3 irq", rdy_irq, 1);
        chk("R3 cnt loaded", cpu_cnt, 3);
        chk("R3 nak cleared", nak, 0);
        pull(3, 0, "R7 pio data");
        cpu_rd = 1; @(negedge clk); cpu_rd = 0;
        chk("R7 empty read", cpu_cnt, 0);

        // R6 bad end and abort
        send_pkt(4, 8'h60, 0, 0);
        @(negedge clk);
        chk("R6 bad irq", rdy_irq, 0);
        chk("R6 bad cnt", cpu_cnt, 0);
        send_abort(2, 8'h70);
        @(negedge clk);
        chk("R6 abort cnt", cpu_cnt, 0);
        send_pkt(2, 8'h80, 1, 1);
        chk("R6 rewind cnt", cpu_cnt, 2);
        pull(2, 0, "R6 rewind data");

        // R4 firmware hold across a swap, engine ignored
        send_pkt(4, 8'h90, 1, 1);
        send_pkt(2, 8'hA0, 1, 1);
        chk("R3 nak second", nak, 1);
        fw_write(1);
        chk("R4 nak forced", nak, 1);
        pull(4, 0, "R7 pio data");
        @(negedge clk);
        chk("R4 swap irq", rdy_irq, 1);
        chk("R4 cnt", cpu_cnt, 2);
        chk("R4 nak survives swap", nak, 1);
        send_pkt(3, 8'hB0, 1, 0);
        chk("R4 nak kept", nak, 1);
        fw_write(0);
        chk("R4 ignored packet not held", nak, 0);
        pull(2, 0, "R4 data");
        @(negedge clk);
        chk("R4 no swap of ignored", rdy_irq, 0);
        chk("R4 cnt", cpu_cnt, 0);

        // R11 overflow
        send_pkt(70, 8'h00, 1, 1);
        chk("R11 cnt saturates", cpu_cnt, 64);
        pull(64, 0, "R11 data");
        chk("R11 drained", cpu_cnt, 0);

        // R8 enable DMA mid-drain, R9 last byte
        send_pkt(6, 8'hC0, 1, 1);
        chk("R8 req off", dma_req, 0);
        pull(2, 0, "R7 pio data");
        dma_en = 1;
        @(negedge clk);
        chk("R8 req immediate", dma_req, 1);
        pull(4, 1, "R7 dma data");
        chk("R9 req after last", dma_req, 0);
        chk("R9 cnt", cpu_cnt, 0);

        // R10 terminal count
        send_pkt(5, 8'hD0, 1, 1);
        chk("R10 irq", rdy_irq, 1);
        chk("R10 req after swap", dma_req, 0);
        @(negedge clk);
        chk("R8 req armed", dma_req, 1);
        pull(2, 1, "R7 dma data");
        dma_tc = 1; @(negedge clk); dma_tc = 0;
        chk("R10 req dropped", dma_req, 0);
        @(negedge clk);
        chk("R10 req stays low", dma_req, 0);
        chk("R10 cnt", cpu_cnt, 3);
        send_pkt(2, 8'hE0, 1, 1);
        pull(3, 0, "R10 pio data");
        chk("R10 req low at zero", dma_req, 0);
        @(negedge clk);
        chk("R10 swap irq", rdy_irq, 1);
        chk("R10 req not yet", dma_req, 0);
        @(negedge clk);
        chk("R10 req rearmed", dma_req, 1);
        pull(2, 1, "R7 dma data");
        chk("R9 req after last", dma_req, 0);
        dma_en = 0;

        // R5 clear
        send_pkt(3, 8'h20, 1, 1);
        send_pkt(2, 8'h30, 1, 1);
        fw_write(1);
        dma_en = 1;
        @(negedge clk);
        chk("R8 req before clr", dma_req, 1);
        clr = 1; @(negedge clk); clr = 0;
        exp_q.delete();
        chk("R5 nak", nak, 0);
        chk("R5 cnt", cpu_cnt, 0);
        chk("R5 req", dma_req, 0);
        dma_en = 0;
        @(negedge clk);
        chk("R5 held dropped irq", rdy_irq, 0);
        chk("R5 held dropped cnt", cpu_cnt, 0);
        send_pkt(2, 8'h50, 1, 1);
        chk("R5 accepts after clr", cpu_cnt, 2);
        pull(2, 0, "R5 data");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule